// File: doc/BRIEF.md
# Threshold-Gated Interrupt Claim Arbiter

This block makes the per-target interrupt decisions of a platform interrupt controller. It keeps two bit vectors across all sources: a pending vector that follows the level of each source input, and an in-service vector. The pending vector is one cycle behind the inputs. Source 0 is reserved and never becomes pending. Each target supplies its own enable mask and a 3-bit threshold. Every source has a 3-bit priority. A source counts for a target when it is pending, not in service, enabled for that target, and its priority is strictly above the target's threshold. The target's request line is high while any source counts for it.

A target claims with a one-cycle pulse. The claim returns the lowest-numbered counting source. The relative priorities of the counting sources play no part in the choice. In the same clock edge, the claimed source's pending bit is cleared and its in-service bit is set. The source then stays masked until a completion pulse names it. If no source counts, the claim returns ID 0 and changes no state.

Each target's claim response is produced by a small state machine with three states. `RSP_IDLE` means no response is shown. `RSP_GRANT` shows a registered non-zero ID. `RSP_EMPTY` shows ID 0. The machine moves to `RSP_GRANT` on a claim pulse that finds a source, to `RSP_EMPTY` on a claim pulse that finds none, and back to `RSP_IDLE` on any cycle without a claim pulse. Claims that arrive together are resolved within the cycle in target order: the source picked by a lower target is hidden from every higher target.

Top module: `irq_claim_arbiter`

## Requirements
- R1: A source can count for target t only if its pending bit is 1, its in-service bit is 0, and its enable bit is 1. The enable bit for source i of target t is `tgt_enable[t*NSRC+i]`.
- R2: An eligible source counts only when its priority is strictly greater than the target's threshold. The priority of source i is `src_prio[3i+2:3i]`. The threshold of target t is `tgt_thresh[3t+2:3t]`.
- R3: `irq[t]` is 1 exactly when at least one source counts for target t, and it is 0 after reset.
- R4: A claim returns the lowest-numbered counting source, whatever the priorities of higher-numbered counting sources.
- R5: On a successful claim, the source's pending bit clears and its in-service bit sets at the same edge. The source then no longer counts for any target while its input level stays high, until it is completed.
- R6: A claim with no counting source returns ID 0 and leaves the pending and in-service state unchanged.
- R7: A completion pulse with ID k clears the in-service bit of source k when k < NSRC. A completion with k >= NSRC has no effect.
- R8: A pending bit takes the source input level one clock after the input changes. Source 0 is never pending.
- R9: `claim_valid[t]` is 1 for exactly the cycle after a `claim_req[t]` pulse, with the ID on `claim_id[t*IDW +: IDW]`. When `claim_valid[t]` is 0, the ID field reads 0.
- R10: When several targets claim in the same cycle, lower target indices are served first, and no source is returned to two targets. When a claim and a level change hit one source in the same cycle, the claim uses the registered pending bit and the pending bit clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_level | input | NSRC | Source input levels (bit 0 ignored) |
| src_prio | input | NSRC*PW | Per-source priority, PW bits per source |
| tgt_enable | input | NTGT*NSRC | Per-target enable masks |
| tgt_thresh | input | NTGT*PW | Per-target thresholds |
| claim_req | input | NTGT | One-cycle claim pulse per target |
| cmpl_req | input | NTGT | One-cycle completion pulse per target |
| cmpl_id | input | NTGT*IDW | Completion source ID per target |
| irq | output | NTGT | Interrupt request per target |
| claim_valid | output | NTGT | Claim response valid per target |
| claim_id | output | NTGT*IDW | Claim response ID per target |

## Verification
A vector table drives single-target claims with these patterns:
- a lone source;
- a low-index, low-priority source beside a higher-index, higher-priority one, to separate index order from priority order;
- sources whose priority equals the threshold, to separate a strict comparison from a non-strict one;
- a masked source, and an input on reserved source 0.

Directed sequences then cover:
- a held-high source that must stay masked after its claim;
- completions with in-range and out-of-range IDs;
- a missed claim followed by a threshold change, which must find the unchanged pending state;
- two targets claiming together with two candidate sources and with one candidate;
- an input level that drops in the same cycle as the claim.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    typedef enum logic [1:0] {
        RSP_IDLE  = 2'd0,
        RSP_GRANT = 2'd1,
        RSP_EMPTY = 2'd2
    } rsp_state_e;
endpackage

// File: rtl/irq_tgt_pick.sv
// Per-target counting vector, request line and lowest-index pick.
module irq_tgt_pick #(
    parameter int NSRC = 12,
    parameter int PW   = 3,
    parameter int IDW  = 4
) (
    input  logic [NSRC-1:0]    avail,
    input  logic [NSRC-1:0]    taken,
    input  logic [NSRC-1:0]    enable,
    input  logic [NSRC*PW-1:0] prio,
    input  logic [PW-1:0]      thresh,
    output logic               irq,
    output logic               hit,
    output logic [IDW-1:0]     pick_id,
    output logic [NSRC-1:0]    pick_onehot
);
    logic [NSRC-1:0] counting;
    logic [NSRC-1:0] cand;

    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            counting[i] = avail[i] & enable[i] & (prio[i*PW +: PW] > thresh);
        end
        irq  = |counting;
        // Sources already handed to a lower target this cycle are hidden.
        cand = counting & ~taken;
        hit         = 1'b0;
        pick_id     = '0;
        pick_onehot = '0;
        // Scan downward so the lowest index is the last to win.
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (cand[i]) begin
                hit         = 1'b1;
                pick_id     = IDW'(i);
                pick_onehot = {{(NSRC-1){1'b0}}, 1'b1} << i;
            end
        end
    end
endmodule

// File: rtl/irq_src_state.sv
// Pending and in-service vectors shared by all targets.
module irq_src_state #(
    parameter int NSRC = 12,
    parameter int NTGT = 2,
    parameter int IDW  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NSRC-1:0]     src_level,
    input  logic [NSRC-1:0]     grant_mask,
    input  logic [NTGT-1:0]     cmpl_req,
    input  logic [NTGT*IDW-1:0] cmpl_id,
    output logic [NSRC-1:0]     pending,
    output logic [NSRC-1:0]     in_service
);
    localparam logic [NSRC-1:0] LIVE_MASK = ~{{(NSRC-1){1'b0}}, 1'b1};

    logic [NSRC-1:0] cmpl_clr;

    always_comb begin
        cmpl_clr = '0;
        for (int t = 0; t < NTGT; t++) begin
            if (cmpl_req[t] && (int'(cmpl_id[t*IDW +: IDW]) < NSRC)) begin
                cmpl_clr[cmpl_id[t*IDW +: IDW]] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending    <= '0;
            in_service <= '0;
        end else begin
            // A grant wins over the input level and over a completion.
            pending    <= src_level & ~grant_mask & LIVE_MASK;
            in_service <= ((in_service & ~cmpl_clr) | grant_mask) & LIVE_MASK;
        end
    end
endmodule

// File: rtl/irq_claim_rsp.sv
// Per-target claim response state machine.
module irq_claim_rsp
    import irq_arb_pkg::*;
#(
    parameter int IDW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           claim,
    input  logic           hit,
    input  logic [IDW-1:0] pick_id,
    output logic           rsp_valid,
    output logic [IDW-1:0] rsp_id
);
    rsp_state_e     state_q, state_d;
    logic [IDW-1:0] id_q;

    always_comb begin
        state_d = RSP_IDLE;
        if (claim) begin
            state_d = hit ? RSP_GRANT : RSP_EMPTY;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
            id_q    <= '0;
        end else begin
            state_q <= state_d;
            id_q    <= (claim && hit) ? pick_id : '0;
        end
    end

    always_comb begin
        unique case (state_q)
            RSP_IDLE:  begin rsp_valid = 1'b0; rsp_id = '0;   end
            RSP_GRANT: begin rsp_valid = 1'b1; rsp_id = id_q; end
            RSP_EMPTY: begin rsp_valid = 1'b1; rsp_id = '0;   end
            default:   begin rsp_valid = 1'b0; rsp_id = '0;   end
        endcase
    end
endmodule

// File: rtl/irq_claim_arbiter.sv
module irq_claim_arbiter #(
    parameter int NSRC = 12,
    parameter int NTGT = 2,
    parameter int PW   = 3,
    parameter int IDW  = $clog2(NSRC)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NSRC-1:0]      src_level,
    input  logic [NSRC*PW-1:0]   src_prio,
    input  logic [NTGT*NSRC-1:0] tgt_enable,
    input  logic [NTGT*PW-1:0]   tgt_thresh,
    input  logic [NTGT-1:0]      claim_req,
    input  logic [NTGT-1:0]      cmpl_req,
    input  logic [NTGT*IDW-1:0]  cmpl_id,
    output logic [NTGT-1:0]      irq,
    output logic [NTGT-1:0]      claim_valid,
    output logic [NTGT*IDW-1:0]  claim_id
);
    logic [NSRC-1:0] pending;
    logic [NSRC-1:0] in_service;
    logic [NSRC-1:0] avail;
    logic [NSRC-1:0] taken [0:NTGT];
    logic [NTGT-1:0] hit;

    assign avail    = pending & ~in_service;
    assign taken[0] = '0;

    irq_src_state #(.NSRC(NSRC), .NTGT(NTGT), .IDW(IDW)) u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_level  (src_level),
        .grant_mask (taken[NTGT]),
        .cmpl_req   (cmpl_req),
        .cmpl_id    (cmpl_id),
        .pending    (pending),
        .in_service (in_service)
    );

    for (genvar t = 0; t < NTGT; t++) begin : g_tgt
        logic [IDW-1:0]  pick_id;
        logic [NSRC-1:0] pick_onehot;

        irq_tgt_pick #(.NSRC(NSRC), .PW(PW), .IDW(IDW)) u_pick (
            .avail       (avail),
            .taken       (taken[t]),
            .enable      (tgt_enable[t*NSRC +: NSRC]),
            .prio        (src_prio),
            .thresh      (tgt_thresh[t*PW +: PW]),
            .irq         (irq[t]),
            .hit         (hit[t]),
            .pick_id     (pick_id),
            .pick_onehot (pick_onehot)
        );

        // Serialise same-cycle claims: lower targets mark their pick first.
        assign taken[t+1] = taken[t] | ((claim_req[t] && hit[t]) ? pick_onehot : '0);

        irq_claim_rsp #(.IDW(IDW)) u_rsp (
            .clk       (clk),
            .rst_n     (rst_n),
            .claim     (claim_req[t]),
            .hit       (hit[t]),
            .pick_id   (pick_id),
            .rsp_valid (claim_valid[t]),
            .rsp_id    (claim_id[t*IDW +: IDW])
        );
    end
endmodule

// File: rtl/irq_claim_arbiter_chk.sv
module irq_claim_arbiter_chk #(
    parameter int NSRC = 12,
    parameter int NTGT = 2,
    parameter int PW   = 3,
    parameter int IDW  = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NTGT-1:0]     claim_req,
    input logic [NTGT-1:0]     irq,
    input logic [NTGT-1:0]     claim_valid,
    input logic [NTGT*IDW-1:0] claim_id
);
    for (genvar t = 0; t < NTGT; t++) begin : g_t
        p_rsp_follows_claim_r9: assert property (@(posedge clk) disable iff (!rst_n)
            claim_req[t] |=> claim_valid[t]);
        p_no_rsp_without_claim_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !claim_req[t] |=> !claim_valid[t]);
        p_idle_id_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !claim_valid[t] |-> (claim_id[t*IDW +: IDW] == '0));
        p_id_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
            claim_valid[t] |-> (int'(claim_id[t*IDW +: IDW]) < NSRC));
        for (genvar u = t + 1; u < NTGT; u++) begin : g_u
            p_no_double_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
                (claim_valid[t] && claim_valid[u] && (claim_id[t*IDW +: IDW] != '0))
                |-> (claim_id[t*IDW +: IDW] != claim_id[u*IDW +: IDW]));
        end
    end

    // Target 0 sees no masking, so its claim hits exactly when its line was high.
    p_miss_iff_no_request_r6: assert property (@(posedge clk) disable iff (!rst_n)
        claim_req[0] |=> ((claim_id[0 +: IDW] != '0) == $past(irq[0])));
endmodule

bind irq_claim_arbiter irq_claim_arbiter_chk #(
    .NSRC(NSRC), .NTGT(NTGT), .PW(PW), .IDW(IDW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .claim_req   (claim_req),
    .irq         (irq),
    .claim_valid (claim_valid),
    .claim_id    (claim_id)
);

// File: tb/tb_irq_claim_arbiter.sv
module tb_irq_claim_arbiter;
    localparam int NSRC = 12;
    localparam int NTGT = 2;
    localparam int PW   = 3;
    localparam int IDW  = 4;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NSRC-1:0]      src_level = '0;
    logic [NSRC*PW-1:0]   src_prio = '0;
    logic [NTGT*NSRC-1:0] tgt_enable = '0;
    logic [NTGT*PW-1:0]   tgt_thresh = '0;
    logic [NTGT-1:0]      claim_req = '0;
    logic [NTGT-1:0]      cmpl_req = '0;
    logic [NTGT*IDW-1:0]  cmpl_id = '0;
    logic [NTGT-1:0]      irq;
    logic [NTGT-1:0]      claim_valid;
    logic [NTGT*IDW-1:0]  claim_id;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_claim_arbiter #(.NSRC(NSRC), .NTGT(NTGT), .PW(PW), .IDW(IDW)) dut (
        .clk(clk), .rst_n(rst_n), .src_level(src_level), .src_prio(src_prio),
        .tgt_enable(tgt_enable), .tgt_thresh(tgt_thresh), .claim_req(claim_req),
        .cmpl_req(cmpl_req), .cmpl_id(cmpl_id), .irq(irq),
        .claim_valid(claim_valid), .claim_id(claim_id)
    );

    // Source priorities: p(i) = 3i mod 8 -> 1:3 2:6 3:1 4:4 5:7 6:2 7:5 8:0 9:3 10:6 11:1
    typedef struct packed {
        logic [11:0] lvl;
        logic [11:0] en;
        logic [2:0]  th;
        logic        exp_irq;
        logic [3:0]  exp_id;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{12'h002, 12'hFFE, 3'd0, 1'b1, 4'd1},   // R4 lone source
        '{12'h006, 12'hFFE, 3'd3, 1'b1, 4'd2},   // R2 src1 prio equals threshold
        '{12'h030, 12'hFFE, 3'd0, 1'b1, 4'd4},   // R4 lower index beats higher prio
        '{12'h030, 12'h020, 3'd0, 1'b1, 4'd5},   // R1 enable mask
        '{12'h100, 12'hFFE, 3'd0, 1'b0, 4'd0},   // R2 prio 0 never counts
        '{12'h0FE, 12'hFFE, 3'd7, 1'b0, 4'd0},   // R2 threshold 7 masks all
        '{12'h001, 12'hFFF, 3'd0, 1'b0, 4'd0},   // R8 source 0 reserved
        '{12'h800, 12'hFFE, 3'd0, 1'b1, 4'd11},  // R4 highest index
        '{12'h000, 12'hFFE, 3'd0, 1'b0, 4'd0},   // R3 nothing pending
        '{12'h006, 12'hFFE, 3'd2, 1'b1, 4'd1}    // R4 index order over priority
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic do_claim(input int t);
        claim_req[t] = 1'b1;
        tick();
        claim_req[t] = 1'b0;
    endtask

    task automatic do_cmpl(input int t, input int id);
        cmpl_req[t] = 1'b1;
        cmpl_id[t*IDW +: IDW] = IDW'(id);
        tick();
        cmpl_req[t] = 1'b0;
    endtask

    function automatic int cid(input int t);
        return int'(claim_id[t*IDW +: IDW]);
    endfunction

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NSRC; i++) src_prio[i*PW +: PW] = PW'((3 * i) % 8);
        tgt_thresh = {3'd7, 3'd0};
        tick();
        tick();
        chk("R3 reset irq", int'(irq), 0);
        chk("R9 reset claim_valid", int'(claim_valid), 0);
        rst_n = 1'b1;
        tick();

        // Vector table on target 0; target 1 masked.
        foreach (VECS[v]) begin
            src_level = VECS[v].lvl;
            tgt_enable = {12'h000, VECS[v].en};
            tgt_thresh = {3'd7, VECS[v].th};
            tick();
            chk($sformatf("R3 vec%0d irq", v), int'(irq[0]), int'(VECS[v].exp_irq));
            do_claim(0);
            chk($sformatf("R9 vec%0d valid", v), int'(claim_valid[0]), 1);
            chk($sformatf("R4 vec%0d id", v), cid(0), int'(VECS[v].exp_id));
            if (VECS[v].exp_id != 0) do_cmpl(0, int'(VECS[v].exp_id));
        end
        src_level = '0;
        tick();
        chk("R9 valid single cycle", int'(claim_valid[0]), 0);

        // R5: held-high source stays masked after claim
        src_level = 12'h008; tgt_enable = {12'h000, 12'hFFE}; tgt_thresh = {3'd7, 3'd0};
        tick();
        do_claim(0);
        chk("R5 claim id", cid(0), 3);
        chk("R5 irq drops", int'(irq[0]), 0);
        tick();
        chk("R5 still masked", int'(irq[0]), 0);
        do_claim(0);
        chk("R5 reclaim empty", cid(0), 0);
        // R7: out-of-range completion ignored, in-range releases
        do_cmpl(0, 12);
        chk("R7 out-of-range ignored", int'(irq[0]), 0);
        do_cmpl(0, 3);
        chk("R7 completion releases", int'(irq[0]), 1);
        do_claim(0);
        chk("R7 reclaim after completion", cid(0), 3);
        do_cmpl(0, 3);
        src_level = '0;
        tick();

        // R6: miss leaves state unchanged
        src_level = 12'h002; tgt_thresh = {3'd7, 3'd7};
        tick();
        do_claim(0);
        chk("R6 miss id", cid(0), 0);
        tgt_thresh = {3'd7, 3'd0};
        #1;
        chk("R6 pending kept", int'(irq[0]), 1);
        do_claim(0);
        chk("R6 later claim", cid(0), 1);
        do_cmpl(0, 1);

        // R10: two targets claim together
        src_level = 12'h240; tgt_enable = {12'hFFE, 12'hFFE}; tgt_thresh = {3'd0, 3'd0};
        tick();
        chk("R3 both targets", int'(irq), 3);
        claim_req = 2'b11;
        tick();
        claim_req = 2'b00;
        chk("R10 target0 id", cid(0), 6);
        chk("R10 target1 id", cid(1), 9);
        do_cmpl(0, 6);
        do_cmpl(1, 9);
        src_level = 12'h040;
        tick();
        claim_req = 2'b11;
        tick();
        claim_req = 2'b00;
        chk("R10 single source t0", cid(0), 6);
        chk("R10 single source t1", cid(1), 0);
        do_cmpl(0, 6);

        // R2/R3: per-target thresholds, src7 prio 5
        src_level = 12'h080; tgt_thresh = {3'd5, 3'd4};
        tick();
        chk("R2 per-target threshold", int'(irq), 1);

        // R10: level drops in the claim cycle
        tgt_thresh = {3'd7, 3'd0};
        claim_req[0] = 1'b1;
        src_level = '0;
        tick();
        claim_req[0] = 1'b0;
        chk("R10 claim beats level drop", cid(0), 7);
        do_cmpl(0, 7);
        chk("R8 no re-pend after drop", int'(irq[0]), 0);

        // R8: one-cycle pending latency
        src_level = 12'h080;
        #1;
        chk("R8 latency before edge", int'(irq[0]), 0);
        tick();
        chk("R8 pending after edge", int'(irq[0]), 1);
        src_level = '0;
        tick();
        chk("R8 pending follows low", int'(irq[0]), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule